// File: doc/BRIEF.md
# Two-Channel Interleaved Thermometer-to-Gray Back End

This block is the digital back end of a 3-bit flash converter built from two identical conversion channels that sample on alternate phases. Each channel receives a 7-bit thermometer word from its own comparator bank, encodes it straight to a 3-bit Gray code and holds it in a flip-flop stage. A merge stage then takes the two channel results in turn and delivers one registered stream at twice the per-channel sampling rate, tagged with the channel that produced each sample.

The two out-of-phase channel clocks are represented by a single fast clock running at twice the channel rate. A small sequencer tracks the phase. Its states are ST_FIRST (the state out of reset: the even channel captures, nothing is merged yet), ST_ODD (the odd channel captures and the merge stage loads the even result) and ST_EVEN (the even channel captures and the merge stage loads the odd result). The transitions are ST_FIRST to ST_ODD, ST_ODD to ST_EVEN and ST_EVEN to ST_ODD, one per fast clock edge.

Each thermometer word has bit 0 tied to the lowest threshold. A word with bubbles, where the ones do not form a contiguous run from bit 0, is encoded from the number of ones it holds.

Top module: `ileave_flash_backend`

## Requirements
- R1: While `rst_n` is low, `out_code` is 000, `out_valid` is 0 and `out_chan` is 0.
- R2: `out_valid` stays low in the cycle before the first clock edge after reset release and in the cycle after that edge. It is high in every cycle after the second edge.
- R3: `out_chan` is 0 (even channel) on the first valid sample and then alternates 1, 0, 1 ... on each following cycle.
- R4: Counting edges from 0 at the first edge after reset release, the even channel samples `therm_even` on even-numbered edges and the odd channel samples `therm_odd` on odd-numbered edges. The input of the channel that is not sampling at an edge has no effect on any output.
- R5: A word sampled at edge k appears on `out_code` right after edge k+1, with `out_chan` equal to the parity of k.
- R6: A clean thermometer word holding n ones (bits 0 to n-1 set) is output as the Gray code for n. Counts 0 to 7 map to 000, 001, 011, 010, 110, 111, 101 and 100.
- R7: A word with bubbles is encoded as the Gray code of its number of ones, using the same table as R6.
- R8: The extreme words are encoded correctly: all zeros gives 000 and all ones gives 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at twice the channel sampling rate |
| rst_n | input | 1 | Active-low synchronous reset |
| therm_even | input | 7 | Thermometer word from the even channel comparators, bit 0 lowest threshold |
| therm_odd | input | 7 | Thermometer word from the odd channel comparators, bit 0 lowest threshold |
| out_code | output | 3 | Merged Gray-coded sample stream |
| out_valid | output | 1 | High when `out_code` carries a sample |
| out_chan | output | 1 | Channel that produced the current sample, 0 even and 1 odd |

## Verification
Capture by one channel and merge of the other channel's earlier result happen on the same fast edge. Each channel register must therefore hold a value for one extra cycle while the merge stage reads it, even as the other channel overwrites its own register. The bench provokes this collision on every edge by driving a fresh, unrelated word on the channel that is not sampling. A scoreboard keyed to the sampling channel then expects the merged output one edge later to match only the word captured before, with the right channel tag. Clean levels, both extreme words, bubble patterns and random words make up the stimulus.

// File: rtl/ileave_pkg.sv
package ileave_pkg;
    typedef enum logic [1:0] {
        ST_FIRST = 2'd0,
        ST_ODD   = 2'd1,
        ST_EVEN  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/thermo_gray_enc.sv
module thermo_gray_enc #(
    parameter int LEVELS = 7,
    parameter int CODE_W = $clog2(LEVELS + 1)
) (
    input  logic [LEVELS-1:0] therm,
    output logic [CODE_W-1:0] gray
);
    logic [CODE_W-1:0] ones;

    // Counting ones tolerates bubbles (R7); the count then becomes Gray (R6)
    always_comb begin
        ones = '0;
        for (int i = 0; i < LEVELS; i++) begin
            ones = ones + CODE_W'(therm[i]);
        end
        gray = ones ^ (ones >> 1);
    end
endmodule

// File: rtl/flash_channel.sv
module flash_channel #(
    parameter int LEVELS = 7,
    parameter int CODE_W = $clog2(LEVELS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [LEVELS-1:0] therm,
    output logic [CODE_W-1:0] code_q
);
    logic [CODE_W-1:0] code_d;

    thermo_gray_enc #(.LEVELS(LEVELS), .CODE_W(CODE_W)) u_enc (
        .therm (therm),
        .gray  (code_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (capture) begin
            code_q <= code_d;
        end
    end

    // R4: outside its own phase the channel result must not move
    a_r4_hold_off_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(code_q));
endmodule

// File: rtl/interleave_seq.sv
module interleave_seq
    import ileave_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic cap_even,
    output logic cap_odd,
    output logic load_out,
    output logic sel_odd
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cap_even = 1'b0;
        cap_odd  = 1'b0;
        load_out = 1'b0;
        sel_odd  = 1'b0;
        unique case (state_q)
            ST_FIRST: begin
                cap_even = 1'b1;
                state_d  = ST_ODD;
            end
            ST_ODD: begin
                cap_odd  = 1'b1;
                load_out = 1'b1;
                sel_odd  = 1'b0;
                state_d  = ST_EVEN;
            end
            ST_EVEN: begin
                cap_even = 1'b1;
                load_out = 1'b1;
                sel_odd  = 1'b1;
                state_d  = ST_ODD;
            end
            default: begin
                state_d = ST_FIRST;
            end
        endcase
    end

    // R4: even and odd capture strictly alternate
    a_r4_even_then_odd: assert property (@(posedge clk) disable iff (!rst_n)
        cap_even |=> cap_odd);
    a_r4_odd_then_even: assert property (@(posedge clk) disable iff (!rst_n)
        cap_odd |=> cap_even);
endmodule

// File: rtl/ileave_flash_backend.sv
module ileave_flash_backend #(
    parameter int LEVELS = 7,
    parameter int CODE_W = $clog2(LEVELS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] therm_even,
    input  logic [LEVELS-1:0] therm_odd,
    output logic [CODE_W-1:0] out_code,
    output logic              out_valid,
    output logic              out_chan
);
    logic              cap_even, cap_odd, load_out, sel_odd;
    logic [CODE_W-1:0] even_code, odd_code;

    interleave_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_even (cap_even),
        .cap_odd  (cap_odd),
        .load_out (load_out),
        .sel_odd  (sel_odd)
    );

    flash_channel #(.LEVELS(LEVELS), .CODE_W(CODE_W)) u_even (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_even),
        .therm   (therm_even),
        .code_q  (even_code)
    );

    flash_channel #(.LEVELS(LEVELS), .CODE_W(CODE_W)) u_odd (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_odd),
        .therm   (therm_odd),
        .code_q  (odd_code)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_code  <= '0;
            out_valid <= 1'b0;
            out_chan  <= 1'b0;
        end else begin
            out_valid <= load_out;
            if (load_out) begin
                out_code <= sel_odd ? odd_code : even_code;
                out_chan <= sel_odd;
            end
        end
    end

    // R2: once valid, the stream never drops
    a_r2_valid_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);
    // R3: consecutive valid samples come from opposite channels
    a_r3_chan_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_chan != $past(out_chan)));
    // R5: an even-tagged sample is the even result held one edge earlier
    a_r5_even_path: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_chan) |-> (out_code == $past(even_code)));
    a_r5_odd_path: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_chan) |-> (out_code == $past(odd_code)));
endmodule

// File: tb/ileave_flash_backend_test.sv
module ileave_flash_backend_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] therm_even = '0;
    logic [6:0] therm_odd = '0;
    logic [2:0] out_code;
    logic       out_valid;
    logic       out_chan;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Scoreboard entry: {requirement class, channel, expected code}
    logic [5:0] sb_q [$];

    // Table from R6
    logic [2:0] gray_tab [8] = '{3'b000, 3'b001, 3'b011, 3'b010,
                                 3'b110, 3'b111, 3'b101, 3'b100};

    always #2.5 clk = ~clk;

    ileave_flash_backend uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .therm_even (therm_even),
        .therm_odd  (therm_odd),
        .out_code   (out_code),
        .out_valid  (out_valid),
        .out_chan   (out_chan)
    );

    function automatic int count_ones(input logic [6:0] w);
        int n = 0;
        for (int i = 0; i < 7; i++) n += int'(w[i]);
        return n;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
        end
    endtask

    // Driver: sets inputs for edge k and pushes the expected merged sample
    task automatic drive(input int k);
        logic [6:0] w;
        logic [1:0] cls; // 0 clean (R6), 1 extreme (R8), 2 bubble or random (R7)
        if (k < 16) begin
            w   = 7'((1 << (k / 2)) - 1);
            cls = ((k / 2) == 0 || (k / 2) == 7) ? 2'd1 : 2'd0;
        end else if (k < 40) begin
            // bubble: clean level with one bit flipped
            w   = 7'((1 << (k % 8)) - 1) ^ 7'(1 << ($urandom % 7));
            cls = 2'd2;
        end else begin
            w   = 7'($urandom);
            cls = 2'd2;
        end
        // R4: the non-sampling channel gets an unrelated word
        if ((k % 2) == 0) begin
            therm_even = w;
            therm_odd  = 7'($urandom);
        end else begin
            therm_odd  = w;
            therm_even = 7'($urandom);
        end
        sb_q.push_back({1'b0, cls, 1'(k % 2), gray_tab[count_ones(w)]});
    endtask

    // Monitor: compares the merged output against the oldest expected entry
    task automatic monitor();
        logic [5:0] e;
        string tag;
        check("R2 valid high", int'(out_valid), 1);
        if (sb_q.size() == 0) begin
            check("R5 scoreboard empty", 0, 1);
            return;
        end
        e = sb_q.pop_front();
        check("R3 channel tag", int'(out_chan), int'(e[3]));
        case (e[5:4])
            2'd0: tag = "R6 clean level (R4 R5)";
            2'd1: tag = "R8 extreme word (R4 R5)";
            default: tag = "R7 bubble/random (R4 R5)";
        endcase
        check(tag, int'(out_code), int'(e[2:0]));
    endtask

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            check("R1 reset code", int'(out_code), 0);
            check("R1 reset valid", int'(out_valid), 0);
            check("R1 reset chan", int'(out_chan), 0);
        end
        rst_n = 1'b1;
        check("R2 valid low before first edge", int'(out_valid), 0);
        drive(0);
        @(negedge clk);
        check("R2 valid low after first edge", int'(out_valid), 0);
        drive(1);
        for (int k = 1; k <= 400; k++) begin
            @(negedge clk);
            monitor();
            drive(k + 1);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule